// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block holds 32-bit control registers behind a simple word bus with separate read and write strobes. The byte address space has two windows. A plain window at byte offset 0 holds registers that take a full overwrite on every write. An aliased window starting at byte offset 0x4000 gives each register four consecutive words. The first word is the register itself and takes an overwrite. The next three words change the register bit by bit: the first sets bits, the second clears them and the third inverts them. The update lands in one bus write, with no read-modify-write sequence on the bus.

A read of any of the four words returns the register's current value. Every register loads a reset value taken from a parameter. Registers marked as PLL-control registers by a parameter mask also have a lock status bit. This bit is forced to 1 at reset and stays 1 whatever is written to the register. Only aligned 4-byte accesses are legal. Any other access changes no state, returns zero if it is a read, and pulses an error flag.

Top module: `sct_regbank`

## Requirements
- R1: After reset, plain register i reads PLAIN_RST[32*i+:32]. Aliased register g reads ALIAS_RST[32*g+:32], with bit LOCK_BIT also set when PLL_MASK[g] is 1. acc_rdata and acc_err are 0.
- R2: The word index is the byte address shifted right by 2. Plain register i sits at byte 4*i. Aliased register g occupies bytes ALIAS_BASE+16*g to ALIAS_BASE+16*g+15, with the word at +0 as the register, +4 as set, +8 as clear and +12 as toggle. Writes to one register never change another.
- R3: A legal write to a plain register, or to the +0 word of an aliased register, replaces the register with acc_wdata.
- R4: A legal write to the set word ORs acc_wdata into the register.
- R5: A legal write to the clear word ANDs the register with the inverse of acc_wdata.
- R6: A legal write to the toggle word XORs acc_wdata into the register.
- R7: A read of the set, clear or toggle word returns the value of the register the word belongs to.
- R8: In a register marked in PLL_MASK, bit LOCK_BIT reads 1 after any write, set, clear or toggle. All other bits follow R3 to R6.
- R9: An access is bad when acc_addr[1:0] is not 0 or acc_bytes is not 4. A bad read or write makes acc_err 1 in the next cycle only, changes no register, and a bad read returns 0.
- R10: A read of a legal address mapped to no register returns 0. A write to such an address changes no register.
- R11: A write takes effect at the clock edge where acc_wr is sampled. acc_rdata shows the read value one cycle after acc_rd. When a read and a write fall in the same cycle, the read returns the value from before the write. acc_rdata holds when acc_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_bytes | input | 3 | Access size in bytes; only 4 is legal |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse after a bad access |

## Verification
A read and a write can land in the same cycle, on the same register or on two alias words of one register. The read must return the value from before the update while the update still takes effect. The bench drives both strobes together on the base word, the set word and the toggle word. The next cycle's read data is compared against the model's pre-write value, and the cycle after that against the updated value. A bad access with both strobes high is also issued: the error must pulse while the register and the read data stay untouched.

// File: rtl/sct_pkg.sv
package sct_pkg;

  // Word offset inside an aliased group; the order is the bus map.
  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_e;

  function automatic logic [31:0] alias_apply(alias_op_e op,
                                              logic [31:0] cur,
                                              logic [31:0] wd);
    logic [31:0] nxt;
    case (op)
      OP_SET:  nxt = cur | wd;
      OP_CLR:  nxt = cur & ~wd;
      OP_TOG:  nxt = cur ^ wd;
      default: nxt = wd;
    endcase
    return nxt;
  endfunction

  function automatic logic word_legal(logic [1:0] lo, logic [2:0] bytes);
    return (lo == 2'b00) && (bytes == 3'd4);
  endfunction

endpackage

// File: rtl/sct_decode.sv
module sct_decode #(
  parameter int ADDR_W     = 15,
  parameter int PLAIN_N    = 4,
  parameter int ALIAS_N    = 4,
  parameter int ALIAS_BASE = 'h4000,
  localparam int PIDX_W    = $clog2(PLAIN_N),
  localparam int GIDX_W    = $clog2(ALIAS_N)
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_bytes,
  output logic              acc_bad,
  output logic              plain_hit,
  output logic              alias_hit,
  output logic [PIDX_W-1:0] plain_idx,
  output logic [GIDX_W-1:0] alias_grp,
  output logic [1:0]        alias_op
);
  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] PLAIN_LIM = ADDR_W'(PLAIN_N * 4);
  localparam logic [ADDR_W-1:0] ALIAS_LIM = ADDR_W'(ALIAS_BASE + ALIAS_N * 16);

  logic [ADDR_W-1:0] off;

  assign off       = acc_addr - BASE_A;
  assign acc_bad   = !sct_pkg::word_legal(acc_addr[1:0], acc_bytes);
  assign plain_hit = !acc_bad && (acc_addr < PLAIN_LIM);
  assign alias_hit = !acc_bad && (acc_addr >= BASE_A) && (acc_addr < ALIAS_LIM);
  assign plain_idx = PIDX_W'(acc_addr >> 2);
  assign alias_grp = GIDX_W'(off >> 4);
  assign alias_op  = off[3:2];
endmodule

// File: rtl/sct_plain_bank.sv
module sct_plain_bank #(
  parameter int                 N   = 4,
  parameter logic [N*32-1:0]    RST = '0,
  localparam int                IW  = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       idx,
  input  logic [31:0]         wdata,
  output logic [N-1:0][31:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= RST[i*32 +: 32];
      else if (we && idx == IW'(i))
        q[i] <= wdata;
    end
  end
endmodule

// File: rtl/sct_alias_bank.sv
module sct_alias_bank #(
  parameter int              N        = 4,
  parameter logic [N*32-1:0] RST      = '0,
  parameter logic [N-1:0]    PLL_MASK = '0,
  parameter int              LOCK_BIT = 31,
  localparam int             IW       = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       grp,
  input  logic [1:0]          op,
  input  logic [31:0]         wdata,
  output logic [N-1:0][31:0]  q
);
  import sct_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [31:0] FORCE = PLL_MASK[g] ? (32'h1 << LOCK_BIT) : 32'h0;
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= RST[g*32 +: 32] | FORCE;
      else if (we && grp == IW'(g))
        q[g] <= alias_apply(alias_op_e'(op), q[g], wdata) | FORCE;
    end
  end
endmodule

// File: rtl/sct_regbank.sv
module sct_regbank #(
  parameter int                    ADDR_W     = 15,
  parameter int                    PLAIN_N    = 4,
  parameter int                    ALIAS_N    = 4,
  parameter int                    ALIAS_BASE = 'h4000,
  parameter logic [PLAIN_N*32-1:0] PLAIN_RST  = {32'h0000_00A5, 32'hFFFF_0000,
                                                 32'h1234_0000, 32'h0000_0042},
  parameter logic [ALIAS_N*32-1:0] ALIAS_RST  = {32'h0001_1001, 32'h1018_101B,
                                                 32'h0001_2000, 32'h0001_3001},
  parameter logic [ALIAS_N-1:0]    PLL_MASK   = 4'b0101,
  parameter int                    LOCK_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_bytes,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err
);
  localparam int PIDX_W = $clog2(PLAIN_N);
  localparam int GIDX_W = $clog2(ALIAS_N);

  logic                     acc_bad;
  logic                     plain_hit;
  logic                     alias_hit;
  logic [PIDX_W-1:0]        plain_idx;
  logic [GIDX_W-1:0]        alias_grp;
  logic [1:0]               alias_op;
  logic [PLAIN_N-1:0][31:0] plain_q;
  logic [ALIAS_N-1:0][31:0] alias_q;
  logic                     plain_we;
  logic                     alias_we;
  logic [31:0]              rd_val;

  sct_decode #(
    .ADDR_W(ADDR_W), .PLAIN_N(PLAIN_N), .ALIAS_N(ALIAS_N), .ALIAS_BASE(ALIAS_BASE)
  ) dec_i (
    .acc_addr(acc_addr), .acc_bytes(acc_bytes), .acc_bad(acc_bad),
    .plain_hit(plain_hit), .alias_hit(alias_hit), .plain_idx(plain_idx),
    .alias_grp(alias_grp), .alias_op(alias_op)
  );

  assign plain_we = acc_wr && plain_hit;
  assign alias_we = acc_wr && alias_hit;

  sct_plain_bank #(.N(PLAIN_N), .RST(PLAIN_RST)) plain_i (
    .clk(clk), .rst(rst), .we(plain_we), .idx(plain_idx),
    .wdata(acc_wdata), .q(plain_q)
  );

  sct_alias_bank #(
    .N(ALIAS_N), .RST(ALIAS_RST), .PLL_MASK(PLL_MASK), .LOCK_BIT(LOCK_BIT)
  ) alias_i (
    .clk(clk), .rst(rst), .we(alias_we), .grp(alias_grp), .op(alias_op),
    .wdata(acc_wdata), .q(alias_q)
  );

  always_comb begin
    rd_val = '0;
    if (plain_hit)
      rd_val = plain_q[plain_idx];
    else if (alias_hit)
      rd_val = alias_q[alias_grp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      if (acc_rd)
        acc_rdata <= rd_val;
      acc_err <= (acc_wr || acc_rd) && acc_bad;
    end
  end
endmodule

// File: rtl/sct_bank_chk.sv
module sct_bank_chk #(
  parameter int                 PLAIN_N  = 4,
  parameter int                 ALIAS_N  = 4,
  parameter logic [ALIAS_N-1:0] PLL_MASK = '0,
  parameter int                 LOCK_BIT = 31,
  localparam int                GIDX_W   = $clog2(ALIAS_N)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     acc_wr,
  input logic                     acc_rd,
  input logic                     acc_err,
  input logic [31:0]              acc_rdata,
  input logic                     acc_bad,
  input logic                     plain_hit,
  input logic                     alias_hit,
  input logic [GIDX_W-1:0]        alias_grp,
  input logic [1:0]               alias_op,
  input logic [PLAIN_N-1:0][31:0] plain_q,
  input logic [ALIAS_N-1:0][31:0] alias_q
);
  // R9
  bad_access_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_wr || acc_rd) && acc_bad |=> acc_err);

  // R9
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_wr || acc_rd) |=> !acc_err);

  // R9
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_bad |=> $stable(plain_q) && $stable(alias_q));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acc_rd && !plain_hit && !alias_hit |=> acc_rdata == 32'h0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(plain_q) && $stable(alias_q));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(acc_rdata));

  for (genvar g = 0; g < ALIAS_N; g++) begin : g_grp
    // R4
    set_grow_chk: assert property (@(posedge clk) disable iff (rst)
      acc_wr && alias_hit && alias_op == 2'd1 && alias_grp == GIDX_W'(g)
      |=> (alias_q[g] & $past(alias_q[g])) == $past(alias_q[g]));

    // R5
    clr_shrink_chk: assert property (@(posedge clk) disable iff (rst)
      acc_wr && alias_hit && alias_op == 2'd2 && alias_grp == GIDX_W'(g)
      |=> (alias_q[g] | $past(alias_q[g])) == $past(alias_q[g]));

    if (PLL_MASK[g]) begin : g_pll
      // R8
      lock_high_chk: assert property (@(posedge clk) disable iff (rst)
        alias_q[g][LOCK_BIT]);
    end
  end
endmodule

bind sct_regbank sct_bank_chk #(
  .PLAIN_N(PLAIN_N), .ALIAS_N(ALIAS_N), .PLL_MASK(PLL_MASK), .LOCK_BIT(LOCK_BIT)
) chk_i (
  .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_err(acc_err),
  .acc_rdata(acc_rdata), .acc_bad(acc_bad), .plain_hit(plain_hit),
  .alias_hit(alias_hit), .alias_grp(alias_grp), .alias_op(alias_op),
  .plain_q(plain_q), .alias_q(alias_q)
);

// File: tb/sct_regbank_tb_top.sv
`timescale 1ns/1ps
module sct_regbank_tb_top;
  localparam int PN    = 4;
  localparam int AN    = 4;
  localparam int ABASE = 16384;
  localparam int LB    = 31;
  localparam logic [PN*32-1:0] PRST = {32'h0000_00A5, 32'hFFFF_0000, 32'h1234_0000, 32'h0000_0042};
  localparam logic [AN*32-1:0] ARST = {32'h0001_1001, 32'h1018_101B, 32'h0001_2000, 32'h0001_3001};
  localparam logic [AN-1:0]    PLLM = 4'b0101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] a_addr = '0;
  logic [2:0]  a_bytes = 3'd4;
  logic        a_wr = 1'b0;
  logic        a_rd = 1'b0;
  logic [31:0] a_wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";
  string exp_tag = "R1";

  logic [31:0] m_plain [PN];
  logic [31:0] m_alias [AN];
  logic [31:0] exp_rdata = '0;
  logic        exp_err = 1'b0;

  always #2.5 clk = ~clk;

  sct_regbank #(
    .ADDR_W(15), .PLAIN_N(PN), .ALIAS_N(AN), .ALIAS_BASE(ABASE),
    .PLAIN_RST(PRST), .ALIAS_RST(ARST), .PLL_MASK(PLLM), .LOCK_BIT(LB)
  ) dut_i (
    .clk(clk), .rst(rst), .acc_addr(a_addr), .acc_bytes(a_bytes),
    .acc_wr(a_wr), .acc_rd(a_rd), .acc_wdata(a_wdata),
    .acc_rdata(rdata), .acc_err(err)
  );

  function automatic logic [31:0] m_read(int a);
    if (a < PN * 4) return m_plain[a / 4];
    if (a >= ABASE && a < ABASE + AN * 16) return m_alias[(a - ABASE) / 16];
    return 32'h0;
  endfunction

  // Behavioural reference, advanced once per clock edge.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PN; i++) m_plain[i] = PRST[i*32 +: 32];
      for (int i = 0; i < AN; i++) begin
        m_alias[i] = ARST[i*32 +: 32];
        if (PLLM[i]) m_alias[i][LB] = 1'b1;
      end
      exp_rdata = 32'h0;
      exp_err   = 1'b0;
    end else begin
      int  a;
      bit  bad;
      a   = int'(a_addr);
      bad = (a % 4 != 0) || (a_bytes != 3'd4);
      exp_err = (a_wr || a_rd) && bad;
      if (a_wr || a_rd) exp_tag = cur_tag;
      if (a_rd) exp_rdata = bad ? 32'h0 : m_read(a);
      if (a_wr && !bad) begin
        if (a < PN * 4) begin
          m_plain[a / 4] = a_wdata;
        end else if (a >= ABASE && a < ABASE + AN * 16) begin
          int g;
          int k;
          g = (a - ABASE) / 16;
          k = ((a - ABASE) / 4) % 4;
          if (k == 0)      m_alias[g] = a_wdata;
          else if (k == 1) m_alias[g] = m_alias[g] | a_wdata;
          else if (k == 2) m_alias[g] = m_alias[g] & ~a_wdata;
          else             m_alias[g] = m_alias[g] ^ a_wdata;
          if (PLLM[g]) m_alias[g][LB] = 1'b1;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (rdata !== exp_rdata || err !== exp_err) begin
        errors++;
        $display("FAIL %s rdata act %h exp %h err act %0b exp %0b",
                 exp_tag, rdata, exp_rdata, err, exp_err);
      end
    end
  end

  task automatic acc(string tag, bit wr, bit rd, int addr, int bytes, logic [31:0] d);
    @(negedge clk);
    cur_tag = tag;
    a_wr    = wr;
    a_rd    = rd;
    a_addr  = 15'(addr);
    a_bytes = 3'(bytes);
    a_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a_wr = 1'b0;
      a_rd = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    idle(2);
    // R1 reset values, R2 map
    for (int i = 0; i < PN; i++) acc("R1", 0, 1, 4 * i, 4, 0);
    for (int g = 0; g < AN; g++) acc("R1", 0, 1, ABASE + 16 * g, 4, 0);
    // R3 overwrite
    acc("R3", 1, 0, 4, 4, 32'hDEAD_BEEF);
    acc("R3", 0, 1, 4, 4, 0);
    acc("R3", 1, 0, ABASE + 16, 4, 32'h0F0F_0F0F);
    acc("R3", 0, 1, ABASE + 16, 4, 0);
    // R4 set, R5 clear, R6 toggle, R7 alias reads
    acc("R4", 1, 0, ABASE + 20, 4, 32'hF000_0000);
    acc("R4", 0, 1, ABASE + 16, 4, 0);
    acc("R5", 1, 0, ABASE + 24, 4, 32'h0000_FFFF);
    acc("R7", 0, 1, ABASE + 28, 4, 0);
    acc("R6", 1, 0, ABASE + 28, 4, 32'hFFFF_FFFF);
    acc("R6", 0, 1, ABASE + 16, 4, 0);
    acc("R7", 0, 1, ABASE + 4, 4, 0);
    acc("R7", 0, 1, ABASE + 8, 4, 0);
    acc("R7", 0, 1, ABASE + 12, 4, 0);
    // R8 lock bit stays set
    acc("R8", 1, 0, ABASE, 4, 32'h0);
    acc("R8", 0, 1, ABASE, 4, 0);
    acc("R8", 1, 0, ABASE + 8, 4, 32'hFFFF_FFFF);
    acc("R8", 0, 1, ABASE, 4, 0);
    acc("R8", 1, 0, ABASE + 12, 4, 32'h8000_0001);
    acc("R8", 0, 1, ABASE + 4, 4, 0);
    acc("R8", 1, 0, ABASE + 32 + 12, 4, 32'hFFFF_FFFF);
    acc("R8", 0, 1, ABASE + 32, 4, 0);
    // R9 bad accesses
    acc("R9", 1, 0, ABASE + 18, 4, 32'h1111_1111);
    acc("R9", 1, 0, ABASE + 16, 2, 32'h2222_2222);
    acc("R9", 0, 1, ABASE + 17, 4, 0);
    acc("R9", 1, 1, 6, 4, 32'h3333_3333);
    acc("R9", 0, 1, ABASE + 16, 1, 0);
    acc("R9", 0, 1, ABASE + 16, 4, 0);
    acc("R9", 0, 1, 4, 4, 0);
    // R10 unmapped
    acc("R10", 0, 1, 64, 4, 0);
    acc("R10", 0, 1, ABASE + AN * 16, 4, 0);
    acc("R10", 1, 0, 256, 4, 32'h5555_AAAA);
    acc("R10", 0, 1, 256, 4, 0);
    acc("R10", 1, 0, ABASE + AN * 16 + 4, 4, 32'hFFFF_FFFF);
    for (int g = 0; g < AN; g++) acc("R10", 0, 1, ABASE + 16 * g, 4, 0);
    // R11 timing and same-cycle read plus write
    acc("R11", 1, 0, 8, 4, 32'hCAFE_0001);
    acc("R11", 0, 1, 8, 4, 0);
    acc("R11", 1, 1, 8, 4, 32'hCAFE_0002);
    acc("R11", 0, 1, 8, 4, 0);
    acc("R11", 1, 1, ABASE + 52, 4, 32'h00FF_0000);
    acc("R11", 1, 1, ABASE + 60, 4, 32'h0000_00FF);
    acc("R11", 0, 1, ABASE + 48, 4, 0);
    idle(3);
    // R2 no cross-talk between neighbours
    acc("R2", 1, 0, 12, 4, 32'hA5A5_A5A5);
    acc("R2", 1, 0, ABASE + 48, 4, 32'h5A5A_5A5A);
    for (int i = 0; i < PN; i++) acc("R2", 0, 1, 4 * i, 4, 0);
    for (int g = 0; g < AN; g++) acc("R2", 0, 1, ABASE + 16 * g, 4, 0);
    // R4 R5 R6 mixed patterns
    begin
      logic [31:0] d;
      d = 32'h1357_9BDF;
      for (int n = 0; n < 24; n++) begin
        d = {d[30:0], d[31] ^ d[21] ^ d[1] ^ d[0]};
        acc((n % 3 == 0) ? "R4" : (n % 3 == 1) ? "R5" : "R6",
            1, 0, ABASE + 16 * (n % AN) + 4 * (1 + n % 3), 4, d);
        acc("R7", 0, 1, ABASE + 16 * (n % AN) + 4 * ((n + 1) % 4), 4, 0);
      end
    end
    idle(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule